// File: doc/BRIEF.md
# Packet Compression Header Selector and Validator

This block decides, once per packet and separately for the transmit and receive paths, which 8-bit compression header governs the packet. The header is either a static value held in a software register or the per-packet header that arrives on the stream sideband. A single mode bit chooses between the two. Bits [7:4] of a header hold the IQ sample width, where code 0 means 16 bits and any other code is the width itself. Bits [3:0] hold the compression method.

The block checks the chosen header against the methods and widths that the build parameters enable. It then corrects the header or flags the packet for dropping. On transmit, an unsupported width is forced to code 0 and a bad method drops the packet. On receive, an unsupported width drops the packet and a bad method is replaced by a default. Each path records its errors in its own sticky register, and software clears a bit by writing one to it. A simple word-addressed bus reads and writes the three registers.

Each path runs a three-state machine. PK_IDLE is the state after reset. On a start-of-packet strobe, the machine moves from any state to PK_PASS when the corrected header is accepted, or to PK_DROP when the packet must be discarded. Without a strobe it stays where it is. The bus side has two states. It moves from BUS_IDLE to BUS_RESP on a read strobe, stays in BUS_RESP while reads continue back to back, and returns to BUS_IDLE otherwise.

Top module: `hdr_ctrl`

## Requirements
- R1: The register at word offset 0 holds the mode bit at bit 8 (0 selects the static header, 1 selects the per-packet header) and the static header at bits [7:0]. Bits [31:9] read as zero, and the register resets to 0.
- R2: The transmit error register sits at offset 1 and the receive error register at offset 2. In both, bit 0 flags a bad method and bit 1 flags a bad width. All other bits read zero, both registers reset to 0, and a read of any offset above 2 returns 0.
- R3: A read returns its data with the valid flag high in exactly the cycle after the read strobe, and the valid flag is low otherwise. The wait signal is always low.
- R4: The effective header equals the static header when the mode bit is 0 and the per-packet input header when the mode bit is 1.
- R5: The header is sampled on the start-of-packet strobe and appears on the outputs the following cycle. Both the header and the drop flag then hold until the next strobe, so a mode change affects only later packets.
- R6: Method code 0000 (none) is always valid. Code 0001 (block floating point) is valid only when BFP_EN is set, and code 0011 (μ-law) only when MULAW_EN is set. Every other code is invalid.
- R7: With EXT_WIDTH off, the supported widths are 9, 12, 14 and 16 (code 0). With EXT_WIDTH on, every width from 8 to 16 is supported.
- R8: On transmit, an unsupported width sets error bit 1 and the output width field becomes 0. The packet is still passed.
- R9: On transmit, an invalid method sets error bit 0 and raises the drop flag for that packet. The header is output unchanged apart from the R8 correction.
- R10: On receive, an unsupported width sets error bit 1 and raises the drop flag. The header is output unchanged.
- R11: On receive, an invalid method sets error bit 0 and the method field is replaced by 0001 if BFP_EN is set, and by 0011 otherwise. The packet is still passed.
- R12: Writing 1 to an error bit clears it and writing 0 leaves it alone. When an error event and a clearing write hit the same bit in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word offset of the register access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rdvalid |
| reg_rdvalid | output | 1 | Read data valid, one cycle after reg_rd |
| reg_wait | output | 1 | Wait request, constantly low |
| tx_sop | input | 1 | Transmit start-of-packet strobe |
| tx_hdr_in | input | 8 | Transmit per-packet header |
| tx_hdr_eff | output | 8 | Transmit effective header |
| tx_drop | output | 1 | Transmit packet must be dropped |
| rx_sop | input | 1 | Receive start-of-packet strobe |
| rx_hdr_in | input | 8 | Receive per-packet header |
| rx_hdr_eff | output | 8 | Receive effective header |
| rx_drop | output | 1 | Receive packet must be dropped |

## Verification
The bench checks the asymmetry between the two paths. A width such as 10 or 11 must be corrected on transmit but must drop the packet on receive, and a reserved method must do the opposite. A design that swapped the rules would still pass a packet, but with the wrong header or the wrong drop flag. Width 8 and width 15 check the edges of the non-extended width set, and a method of none checks that a zero code is not treated as bad.

The bench changes the mode between packets and confirms that the held header does not move until the next strobe. A design that selected the header combinationally would change its output mid-packet. Finally, the bench fires an error event and a clearing write in the same cycle. A design that let the write win would lose the error.

// File: rtl/hdr_ctrl_pkg.sv
package hdr_ctrl_pkg;

    localparam int HDR_W    = 8;
    localparam int OFS_MODE = 0;
    localparam int OFS_TERR = 1;
    localparam int OFS_RERR = 2;

    typedef struct packed {
        logic [3:0] width;
        logic [3:0] meth;
    } hdr_t;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_PASS = 2'd1,
        PK_DROP = 2'd2
    } pk_state_t;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    localparam logic [3:0] METH_NONE = 4'b0000;
    localparam logic [3:0] METH_BFP  = 4'b0001;
    localparam logic [3:0] METH_MU   = 4'b0011;

    function automatic logic width_ok(input logic [3:0] code, input logic ext);
        logic r;
        case (code)
            4'd0, 4'd9, 4'd12, 4'd14:         r = 1'b1;
            4'd8, 4'd10, 4'd11, 4'd13, 4'd15: r = ext;
            default:                          r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic method_ok(input logic [3:0] m, input logic bfp, input logic mu);
        logic r;
        case (m)
            METH_NONE: r = 1'b1;
            METH_BFP:  r = bfp;
            METH_MU:   r = mu;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hdr_check.sv
module hdr_check
    import hdr_ctrl_pkg::*;
#(
    parameter bit IS_RX     = 1'b0,
    parameter bit BFP_EN    = 1'b1,
    parameter bit MULAW_EN  = 1'b1,
    parameter bit EXT_WIDTH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sop,
    input  logic             dyn_mode,
    input  logic [HDR_W-1:0] static_hdr,
    input  logic [HDR_W-1:0] pkt_hdr,
    output logic [HDR_W-1:0] hdr_eff,
    output logic             drop,
    output logic             err_meth,
    output logic             err_width
);

    localparam logic [3:0] DEF_METH = BFP_EN ? METH_BFP : METH_MU;

    pk_state_t st_q, st_d;
    hdr_t      src, fixed, hdr_q;
    logic      w_ok, m_ok, accept;

    assign src  = dyn_mode ? hdr_t'(pkt_hdr) : hdr_t'(static_hdr);
    assign w_ok = width_ok(src.width, EXT_WIDTH);
    assign m_ok = method_ok(src.meth, BFP_EN, MULAW_EN);

    generate
        if (IS_RX) begin : g_rx
            assign fixed  = '{width: src.width, meth: (m_ok ? src.meth : DEF_METH)};
            assign accept = w_ok;
        end else begin : g_tx
            assign fixed  = '{width: (w_ok ? src.width : 4'd0), meth: src.meth};
            assign accept = m_ok;
        end
    endgenerate

    assign err_meth  = sop && !m_ok;
    assign err_width = sop && !w_ok;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PK_IDLE: if (sop) st_d = accept ? PK_PASS : PK_DROP;
            PK_PASS: if (sop) st_d = accept ? PK_PASS : PK_DROP;
            PK_DROP: if (sop) st_d = accept ? PK_PASS : PK_DROP;
            default: st_d = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PK_IDLE;
            hdr_q <= '0;
        end else begin
            st_q <= st_d;
            if (sop) hdr_q <= fixed;
        end
    end

    always_comb begin
        hdr_eff = hdr_q;
        drop    = (st_q == PK_DROP);
    end

endmodule

// File: rtl/hdr_regs.sv
module hdr_regs
    import hdr_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int REG_W  = 32,
    parameter int NPATH  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_rd,
    input  logic                       reg_wr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output logic                       reg_rdvalid,
    input  logic [NPATH-1:0][1:0]      err_set,
    output logic                       dyn_mode,
    output logic [HDR_W-1:0]           static_hdr
);

    localparam int MODE_BITS = HDR_W + 1;

    bus_state_t              bus_q;
    logic [MODE_BITS-1:0]    mode_q;
    logic [NPATH-1:0][1:0]   err_q;
    logic [REG_W-1:0]        rd_mux, rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (reg_wr && reg_addr == ADDR_W'(OFS_MODE)) begin
            mode_q <= reg_wdata[MODE_BITS-1:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NPATH; gi++) begin : g_err
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    err_q[gi] <= '0;
                end else if (reg_wr && reg_addr == ADDR_W'(OFS_TERR + gi)) begin
                    err_q[gi] <= (err_q[gi] & ~reg_wdata[1:0]) | err_set[gi];
                end else begin
                    err_q[gi] <= err_q[gi] | err_set[gi];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(OFS_MODE)) begin
            rd_mux[MODE_BITS-1:0] = mode_q;
        end
        for (int i = 0; i < NPATH; i++) begin
            if (reg_addr == ADDR_W'(OFS_TERR + i)) rd_mux[1:0] = err_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q   <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            unique case (bus_q)
                BUS_IDLE: bus_q <= reg_rd ? BUS_RESP : BUS_IDLE;
                BUS_RESP: bus_q <= reg_rd ? BUS_RESP : BUS_IDLE;
                default:  bus_q <= BUS_IDLE;
            endcase
            rdata_q <= reg_rd ? rd_mux : '0;
        end
    end

    always_comb begin
        reg_rdvalid = (bus_q == BUS_RESP);
        reg_rdata   = rdata_q;
        dyn_mode    = mode_q[HDR_W];
        static_hdr  = mode_q[HDR_W-1:0];
    end

endmodule

// File: rtl/hdr_ctrl.sv
module hdr_ctrl
    import hdr_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter bit BFP_EN    = 1'b1,
    parameter bit MULAW_EN  = 1'b1,
    parameter bit EXT_WIDTH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rdvalid,
    output logic              reg_wait,
    input  logic              tx_sop,
    input  logic [7:0]        tx_hdr_in,
    output logic [7:0]        tx_hdr_eff,
    output logic              tx_drop,
    input  logic              rx_sop,
    input  logic [7:0]        rx_hdr_in,
    output logic [7:0]        rx_hdr_eff,
    output logic              rx_drop
);

    logic             dyn_mode;
    logic [HDR_W-1:0] static_hdr;
    logic [1:0][1:0]  err_set;

    assign reg_wait = 1'b0;

    hdr_regs #(.ADDR_W(ADDR_W), .REG_W(32), .NPATH(2)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rdvalid(reg_rdvalid),
        .err_set    (err_set),
        .dyn_mode   (dyn_mode),
        .static_hdr (static_hdr)
    );

    hdr_check #(.IS_RX(1'b0), .BFP_EN(BFP_EN), .MULAW_EN(MULAW_EN), .EXT_WIDTH(EXT_WIDTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sop       (tx_sop),
        .dyn_mode  (dyn_mode),
        .static_hdr(static_hdr),
        .pkt_hdr   (tx_hdr_in),
        .hdr_eff   (tx_hdr_eff),
        .drop      (tx_drop),
        .err_meth  (err_set[0][0]),
        .err_width (err_set[0][1])
    );

    hdr_check #(.IS_RX(1'b1), .BFP_EN(BFP_EN), .MULAW_EN(MULAW_EN), .EXT_WIDTH(EXT_WIDTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sop       (rx_sop),
        .dyn_mode  (dyn_mode),
        .static_hdr(static_hdr),
        .pkt_hdr   (rx_hdr_in),
        .hdr_eff   (rx_hdr_eff),
        .drop      (rx_drop),
        .err_meth  (err_set[1][0]),
        .err_width (err_set[1][1])
    );

endmodule

// File: rtl/hdr_ctrl_chk.sv
module hdr_ctrl_chk
    import hdr_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter bit BFP_EN    = 1'b1,
    parameter bit MULAW_EN  = 1'b1,
    parameter bit EXT_WIDTH = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [31:0]       reg_rdata,
    input logic              reg_rdvalid,
    input logic              reg_wait,
    input logic              tx_sop,
    input logic [7:0]        tx_hdr_eff,
    input logic              tx_drop,
    input logic              rx_sop,
    input logic [7:0]        rx_hdr_eff,
    input logic              rx_drop
);

    p_wait_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wait == 1'b0);

    p_rdvalid_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rdvalid);

    p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rdvalid);

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > ADDR_W'(OFS_RERR)) |=> reg_rdata == 32'd0);

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sop |=> ($stable(tx_hdr_eff) && $stable(tx_drop)));

    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sop |=> ($stable(rx_hdr_eff) && $stable(rx_drop)));

    p_tx_width_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sop |=> width_ok(tx_hdr_eff[7:4], EXT_WIDTH));

    p_rx_meth_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sop |=> method_ok(rx_hdr_eff[3:0], BFP_EN, MULAW_EN));

endmodule

bind hdr_ctrl hdr_ctrl_chk #(
    .ADDR_W(ADDR_W), .BFP_EN(BFP_EN), .MULAW_EN(MULAW_EN), .EXT_WIDTH(EXT_WIDTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .reg_rdvalid(reg_rdvalid),
    .reg_wait   (reg_wait),
    .tx_sop     (tx_sop),
    .tx_hdr_eff (tx_hdr_eff),
    .tx_drop    (tx_drop),
    .rx_sop     (rx_sop),
    .rx_hdr_eff (rx_hdr_eff),
    .rx_drop    (rx_drop)
);

// File: tb/hdr_ctrl_test.sv
module hdr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rdvalid;
    logic        reg_wait;
    logic        tx_sop = 1'b0;
    logic [7:0]  tx_hdr_in = '0;
    logic [7:0]  tx_hdr_eff;
    logic        tx_drop;
    logic        rx_sop = 1'b0;
    logic [7:0]  rx_hdr_in = '0;
    logic [7:0]  rx_hdr_eff;
    logic        rx_drop;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    hdr_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rdvalid(reg_rdvalid), .reg_wait(reg_wait),
        .tx_sop(tx_sop), .tx_hdr_in(tx_hdr_in), .tx_hdr_eff(tx_hdr_eff), .tx_drop(tx_drop),
        .rx_sop(rx_sop), .rx_hdr_in(rx_hdr_in), .rx_hdr_eff(rx_hdr_eff), .rx_drop(rx_drop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R3 rdvalid after read", {31'd0, reg_rdvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic tx_pkt(input logic [7:0] h);
        @(negedge clk);
        tx_sop = 1'b1; tx_hdr_in = h;
        @(negedge clk);
        tx_sop = 1'b0;
    endtask

    task automatic rx_pkt(input logic [7:0] h);
        @(negedge clk);
        rx_sop = 1'b1; rx_hdr_in = h;
        @(negedge clk);
        rx_sop = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R5 reset tx header", {24'd0, tx_hdr_eff}, 32'd0);
        chk("R5 reset tx drop", {31'd0, tx_drop}, 32'd0);
        chk("R3 reset rdvalid", {31'd0, reg_rdvalid}, 32'd0);
        chk("R3 wait low", {31'd0, reg_wait}, 32'd0);
        bus_rd(4'd0, d); chk("R1 mode reset", d, 32'd0);
        bus_rd(4'd1, d); chk("R2 tx err reset", d, 32'd0);
        bus_rd(4'd2, d); chk("R2 rx err reset", d, 32'd0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_wr(4'd0, 32'hFFFF_FFFF);
        bus_rd(4'd0, d); chk("R1 upper bits zero", d, 32'h0000_01FF);
        @(negedge clk);
        chk("R3 rdvalid drops", {31'd0, reg_rdvalid}, 32'd0);
        bus_rd(4'd3, d); chk("R2 unmapped offset", d, 32'd0);
        bus_wr(4'd0, 32'h0000_0091);
        bus_rd(4'd0, d); chk("R1 static header", d, 32'h91);
    endtask

    task automatic t_select;
        tx_pkt(8'h33);
        chk("R4 static hdr used", {24'd0, tx_hdr_eff}, 32'h91);
        chk("R4 static no drop", {31'd0, tx_drop}, 32'd0);
        bus_wr(4'd0, 32'h0000_01C3);
        tx_pkt(8'hC3);
        chk("R4 dynamic hdr used", {24'd0, tx_hdr_eff}, 32'hC3);
        rx_pkt(8'h00);
        chk("R6 method none width16", {24'd0, rx_hdr_eff}, 32'h00);
        chk("R6 method none no drop", {31'd0, rx_drop}, 32'd0);
    endtask

    task automatic t_hold;
        bus_wr(4'd0, 32'h0000_0091);
        repeat (3) @(negedge clk);
        chk("R5 header held after mode change", {24'd0, tx_hdr_eff}, 32'hC3);
        tx_pkt(8'hC3);
        chk("R5 new mode on next packet", {24'd0, tx_hdr_eff}, 32'h91);
        bus_wr(4'd0, 32'h0000_0100);
    endtask

    task automatic t_tx_errors;
        logic [31:0] d;
        tx_pkt(8'hA1);
        chk("R8 tx width forced", {24'd0, tx_hdr_eff}, 32'h01);
        chk("R8 tx width no drop", {31'd0, tx_drop}, 32'd0);
        bus_rd(4'd1, d); chk("R8 tx width err bit", d, 32'd2);
        tx_pkt(8'hF3);
        chk("R7 width 15 unsupported", {24'd0, tx_hdr_eff}, 32'h03);
        tx_pkt(8'hC2);
        chk("R9 tx bad method drop", {31'd0, tx_drop}, 32'd1);
        chk("R9 tx header kept", {24'd0, tx_hdr_eff}, 32'hC2);
        bus_rd(4'd1, d); chk("R9 tx both err bits", d, 32'd3);
        bus_wr(4'd1, 32'd1);
        bus_rd(4'd1, d); chk("R12 selective clear", d, 32'd2);
        tx_pkt(8'hE1);
        chk("R9 drop released on good packet", {31'd0, tx_drop}, 32'd0);
        bus_wr(4'd1, 32'd3);
        bus_rd(4'd1, d); chk("R12 full clear", d, 32'd0);
    endtask

    task automatic t_rx_errors;
        logic [31:0] d;
        rx_pkt(8'hB1);
        chk("R10 rx bad width drop", {31'd0, rx_drop}, 32'd1);
        chk("R10 rx header kept", {24'd0, rx_hdr_eff}, 32'hB1);
        bus_rd(4'd2, d); chk("R10 rx width err bit", d, 32'd2);
        bus_rd(4'd1, d); chk("R2 tx reg untouched by rx", d, 32'd0);
        rx_pkt(8'h81);
        chk("R7 width 8 unsupported", {31'd0, rx_drop}, 32'd1);
        bus_wr(4'd2, 32'd2);
        rx_pkt(8'hE5);
        chk("R11 rx method defaulted", {24'd0, rx_hdr_eff}, 32'hE1);
        chk("R11 rx no drop", {31'd0, rx_drop}, 32'd0);
        bus_rd(4'd2, d); chk("R11 rx method err bit", d, 32'd1);
        rx_pkt(8'h93);
        chk("R6 mu-law accepted", {24'd0, rx_hdr_eff}, 32'h93);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        @(negedge clk);
        tx_sop = 1'b1; tx_hdr_in = 8'hC2;
        reg_addr = 4'd1; reg_wdata = 32'd1; reg_wr = 1'b1;
        @(negedge clk);
        tx_sop = 1'b0; reg_wr = 1'b0;
        bus_rd(4'd1, d); chk("R12 event beats clear", d, 32'd1);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_select();
        t_hold();
        t_tx_errors();
        t_rx_errors();
        t_set_wins();
        done = 1;
        finish_run();
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule